// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a serial peripheral (SPI) master that a processor drives through a small 32-bit register port. Software loads up to 128 bits of outgoing data into four data words and picks a length, bit order and the clock edges used for driving and sampling. It then sets a start bit. The block produces the serial clock from the system clock through a programmable divider. It shifts the data out on `mosi`, collects the reply from `miso` and leaves the reply in the same four data words.

The slave-select lines are active low. They either follow a register directly, or, in automatic mode, are asserted only while a transfer is running. A completion interrupt can be enabled. It is cleared by reading any data word. The register port answers every strobe one cycle later. While a transfer is in flight the data words and the control word are locked, but the divider and slave-select registers stay writable.

Top module: `spi_master_regs`

## Requirements
- R1: After a synchronous reset, every register reads as zero, `ss_n` is all ones, and `sclk` and `irq` are low.
- R2: Control bits [6:0] give the transfer length in bits. The value 0 means 128 bits.
- R3: Writing control with bit 8 set while idle starts a transfer. Bit 8 reads 1 while the transfer runs and reads 0 once it has ended. The other control fields read back as written.
- R4: Control bit 9 set makes the block sample `miso` on falling `sclk` edges (clear: rising). Control bit 10 set makes it change `mosi` on falling edges (clear: rising).
- R5: With control bit 11 clear, bit L-1 of the data register is sent first. With bit 11 set, bit 0 is sent first.
- R6: With control bit 12 set, `irq` rises when a transfer ends. It is low again within one clock after a read of any data word.
- R7: With control bit 13 set, `ss_n` is all ones while idle and equals the bitwise inverse of the slave-select register while busy.
- R8: With control bit 13 clear, `ss_n` always equals the inverse of the slave-select register. The register sits at byte offset 0x18.
- R9: `sclk` idles low. Each of its high and low phases lasts (divider+1) clocks. The divider sits at offset 0x14.
- R10: `bus_ack` pulses one cycle after the strobe. Writes to the data words or to control are ignored while a transfer is busy.
- R11: Byte offsets 0x00 to 0x0C address the four 32-bit slices of one 128-bit register, with word 0 holding bits 31:0. Received bit k lands where transmit bit k was taken from. Bits at and above the length keep their written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_stb | input | 1 | Access strobe, held until acknowledged |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| irq | output | 1 | Transfer-complete interrupt |
| ss_n | output | SS_W | Active-low slave selects |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong bit pointer or edge-phase state shows up as a reordered or shifted bit pattern. It appears at the slave model as soon as the transfer ends, and in the data words on the next read. A wrong divider count shows in the measured `sclk` phase widths within the first serial clock period. A stale busy state shows as `ss_n` staying asserted or control bit 8 staying set, which the next status poll exposes. The bench also writes during a transfer, so a missing busy lock corrupts the readback seen right after completion.

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs #(
  parameter int DIV_W = 16,
  parameter int SS_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_we,
  input  logic            bus_stb,
  output logic            bus_ack,
  output logic [31:0]     bus_rdata,
  output logic            irq,
  output logic [SS_W-1:0] ss_n,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso
);
  localparam int WORDS = 4;
  localparam int SR_W  = 32 * WORDS;

  logic [SR_W-1:0]  shreg;
  logic [6:0]       len;
  logic             cap_fall, drv_fall, lsb_first, ie, auto_ss, busy;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [SS_W-1:0]  ss_q;
  logic [7:0]       edge_cnt;

  wire       acc     = bus_stb & ~bus_ack;
  wire       wr      = acc & bus_we;
  wire [2:0] reg_sel = bus_addr[4:2];
  wire       tick    = busy && (div_cnt >= div_q);
  wire [6:0] lastpos = len - 7'd1;
  wire [6:0] bit_k   = edge_cnt[7:1];
  wire       falling = edge_cnt[0];
  wire [6:0] pos_now  = lsb_first ? bit_k : lastpos - bit_k;
  wire [6:0] pos_next = lsb_first ? bit_k + 7'd1 : lastpos - bit_k - 7'd1;
  wire [6:0] pos_first = bus_wdata[11] ? 7'd0 : bus_wdata[6:0] - 7'd1;
  wire [31:0] ctrl_rd = {18'd0, auto_ss, ie, lsb_first, drv_fall, cap_fall, busy, 1'b0, len};

  assign ss_n = ~(ss_q & {SS_W{busy | ~auto_ss}});

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; len <= '0; cap_fall <= 1'b0; drv_fall <= 1'b0; lsb_first <= 1'b0;
      ie <= 1'b0; auto_ss <= 1'b0; busy <= 1'b0; div_q <= '0; div_cnt <= '0;
      ss_q <= '0; edge_cnt <= '0; bus_ack <= 1'b0; bus_rdata <= '0; irq <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0;
    end else begin
      bus_ack <= bus_stb & ~bus_ack;
      if (acc) begin
        case (reg_sel)
          3'd0, 3'd1, 3'd2, 3'd3: bus_rdata <= shreg[{reg_sel[1:0], 5'd0} +: 32];
          3'd4:    bus_rdata <= ctrl_rd;
          3'd5:    bus_rdata <= 32'(div_q);
          3'd6:    bus_rdata <= 32'(ss_q);
          default: bus_rdata <= '0;
        endcase
      end
      if (acc && !bus_we && !reg_sel[2]) irq <= 1'b0;
      if (wr) begin
        if (reg_sel == 3'd5) div_q <= bus_wdata[DIV_W-1:0];
        if (reg_sel == 3'd6) ss_q <= bus_wdata[SS_W-1:0];
        if (!busy) begin
          if (!reg_sel[2]) shreg[{reg_sel[1:0], 5'd0} +: 32] <= bus_wdata;
          if (reg_sel == 3'd4) begin
            len       <= bus_wdata[6:0];
            cap_fall  <= bus_wdata[9];
            drv_fall  <= bus_wdata[10];
            lsb_first <= bus_wdata[11];
            ie        <= bus_wdata[12];
            auto_ss   <= bus_wdata[13];
            if (bus_wdata[8]) begin
              busy     <= 1'b1;
              edge_cnt <= '0;
              div_cnt  <= '0;
              irq      <= 1'b0;
              if (bus_wdata[10]) mosi <= shreg[pos_first];
            end
          end
        end
      end
      if (busy) begin
        if (tick) begin
          div_cnt <= '0;
          sclk    <= ~sclk;
          if (!falling && !drv_fall) mosi <= shreg[pos_now];
          if (falling && drv_fall && bit_k != lastpos) mosi <= shreg[pos_next];
          if (falling == cap_fall) shreg[pos_now] <= miso;
          if (falling && bit_k == lastpos) begin
            busy <= 1'b0;
            if (ie) irq <= 1'b1;
          end else begin
            edge_cnt <= edge_cnt + 8'd1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk); // R9
  AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst) !(busy && div_cnt >= div_q) |=> $stable(sclk)); // R9
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (rst) (busy && div_cnt < div_q) |=> $stable(shreg)); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) bus_ack |=> !bus_ack); // R10
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst) ($fell(busy) && ie) |-> irq); // R6
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) busy |-> (edge_cnt[7:1] <= lastpos)); // R2
endmodule

// File: tb/spi_master_regs_tb.sv
`timescale 1ns/1ps
module spi_master_regs_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0, stb = 1'b0;
  logic ack, irq, sclk, mosi;
  logic [31:0] rdata;
  logic [7:0] ss_n;
  logic miso_b = 1'b0;

  always #2 clk = ~clk;

  spi_master_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_stb(stb), .bus_ack(ack), .bus_rdata(rdata), .irq(irq),
    .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso_b)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] last_rd;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct { bit care; logic [31:0] exp; string req; } item_t;
  item_t sb_q[$];

  always @(posedge clk) begin
    #1;
    if (ack && !we) begin
      last_rd = rdata;
      if (sb_q.size() == 0) chk(1'b0, "scoreboard underflow", '0, '0);
      else begin
        item_t it = sb_q.pop_front();
        if (it.care) chk(rdata == it.exp, it.req, rdata, it.exp);
      end
    end
  end

  task automatic bus_op(input logic [4:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = w; wdata = d; stb = 1'b1;
    do @(negedge clk); while (!ack);
    stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_op(a, 1'b1, d);
  endtask

  task automatic rd(input logic [4:0] a, input bit care, input logic [31:0] exp, input string req);
    item_t it;
    it.care = care; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    bus_op(a, 1'b0, 32'd0);
  endtask

  // slave model
  logic [127:0] spat, got;
  int sidx;
  bit s_capfall, s_drvfall;

  always @(negedge sclk) if (!s_capfall && sidx < 127) begin sidx = sidx + 1; miso_b = spat[127-sidx]; end
  always @(posedge sclk) if (s_capfall && sidx < 128) begin miso_b = spat[127-sidx]; sidx = sidx + 1; end
  always @(posedge sclk) if (s_drvfall) got = {got[126:0], mosi};
  always @(negedge sclk) if (!s_drvfall) got = {got[126:0], mosi};

  function automatic logic [127:0] exp_rx(logic [127:0] tx, logic [127:0] pat, int len, bit lsb);
    logic [127:0] r = tx;
    for (int k = 0; k < len; k++) r[lsb ? k : len-1-k] = pat[127-k];
    return r;
  endfunction

  function automatic logic [127:0] exp_line(logic [127:0] tx, int len, bit lsb);
    logic [127:0] e = '0;
    for (int k = 0; k < len; k++) e = {e[126:0], tx[lsb ? k : len-1-k]};
    return e;
  endfunction

  logic [7:0] ss_val;
  int div_val;

  task automatic xfer(input logic [31:0] ctrl, input logic [127:0] tx, input logic [127:0] pat, input bit measure);
    int len = (ctrl[6:0] == 0) ? 128 : int'(ctrl[6:0]);
    bit lsb = ctrl[11];
    logic [127:0] er = exp_rx(tx, pat, len, lsb);
    logic [127:0] em = exp_line(tx, len, lsb);
    logic [127:0] mask = (len == 128) ? '1 : ((128'd1 << len) - 128'd1);
    int h, l, t;
    for (int w = 0; w < 4; w++) wr(5'(w*4), tx[w*32 +: 32]);
    s_capfall = ctrl[9]; s_drvfall = ctrl[10]; spat = pat; got = '0; sidx = 0; miso_b = pat[127];
    if (ctrl[13]) begin
      wr(5'h10, ctrl);
      @(negedge clk);
      chk(ss_n == 8'hFF, "R7 idle ss_n high", ss_n, 8'hFF);
    end
    wr(5'h10, ctrl | 32'h100);
    if (ctrl[13]) begin
      @(negedge clk);
      chk(ss_n == ~ss_val, "R7 ss_n asserted while busy", ss_n, ~ss_val);
    end else begin
      chk(ss_n == ~ss_val, "R8 manual ss_n", ss_n, ~ss_val);
    end
    if (measure) begin
      @(posedge sclk);
      h = 0; l = 0;
      @(negedge clk);
      while (sclk) begin h++; @(negedge clk); end
      while (!sclk) begin l++; @(negedge clk); end
      chk(h == div_val + 1, "R9 sclk high phase", 128'(h), 128'(div_val + 1));
      chk(l == div_val + 1, "R9 sclk low phase", 128'(l), 128'(div_val + 1));
      wr(5'h00, 32'hDEADBEEF);
      wr(5'h10, 32'h00000A05);
      rd(5'h10, 1'b1, ctrl | 32'h100, "R3 busy bit set during transfer, R10 ctrl write ignored");
    end
    if (ctrl[12]) begin
      t = 0;
      while (!irq && t < 20000) begin @(negedge clk); t++; end
      chk(irq, "R6 irq raised at completion", 128'(irq), 128'd1);
      rd(5'h10, 1'b1, ctrl, "R3 busy self-cleared");
    end else begin
      do rd(5'h10, 1'b0, 32'd0, ""); while (last_rd[8]);
      chk(last_rd == ctrl, "R3 busy self-cleared, fields kept", last_rd, ctrl);
    end
    rd(5'h00, 1'b1, er[31:0], "R11 word0 received");
    if (ctrl[12]) chk(!irq, "R6 irq cleared by data read", 128'(irq), 128'd0);
    rd(5'h04, 1'b1, er[63:32], "R11 word1 received");
    rd(5'h08, 1'b1, er[95:64], "R11 word2 received");
    rd(5'h0C, 1'b1, er[127:96], "R11 word3 received");
    chk(((got ^ em) & mask) == '0, "R5 R4 R2 serial out order", got & mask, em);
    if (ctrl[13]) chk(ss_n == 8'hFF, "R7 ss_n released", ss_n, 8'hFF);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    s_capfall = 0; s_drvfall = 0; spat = '0; got = '0; sidx = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(ss_n == 8'hFF && !sclk && !irq, "R1 reset outputs", {ss_n, sclk, irq}, {8'hFF, 2'b00});
    rd(5'h00, 1'b1, 32'd0, "R1 word0 reset");
    rd(5'h0C, 1'b1, 32'd0, "R1 word3 reset");
    rd(5'h10, 1'b1, 32'd0, "R1 ctrl reset");
    rd(5'h14, 1'b1, 32'd0, "R1 divider reset");
    rd(5'h18, 1'b1, 32'd0, "R1 select reset");

    // R10 ack exactly one cycle after strobe
    @(negedge clk); addr = 5'h14; we = 1'b0; stb = 1'b1;
    sb_q.push_back('{1'b1, 32'd0, "R10 read during ack check"});
    chk(!ack, "R10 no ack in strobe cycle", 128'(ack), 128'd0);
    @(negedge clk);
    chk(ack, "R10 ack one cycle later", 128'(ack), 128'd1);
    stb = 1'b0;
    @(negedge clk);
    chk(!ack, "R10 ack single pulse", 128'(ack), 128'd0);

    ss_val = 8'hA5; div_val = 0;
    wr(5'h18, {24'd0, ss_val});
    rd(5'h18, 1'b1, 32'hA5, "R8 select readback");
    @(negedge clk);
    chk(ss_n == 8'h5A, "R8 manual ss_n inverse", ss_n, 8'h5A);
    ss_val = 8'h01;
    wr(5'h18, 32'h01);
    wr(5'h14, 32'd0);

    xfer(32'h0208, 128'h5A, {8'hA5, 120'h0}, 1'b0);
    xfer(32'h0408, 128'hA5, {8'h96, 120'h0}, 1'b0);
    xfer(32'h0C10, 128'h5AA5, {16'hA55A, 112'h0}, 1'b0);
    xfer(32'h0A40, {64'h0, 64'hFEDCBA98_76543210}, {64'h5AA5A55A_1234C3D2, 64'h0}, 1'b0);
    div_val = 2;
    wr(5'h14, 32'd2);
    rd(5'h14, 1'b1, 32'd2, "R9 divider readback");
    xfer(32'h0400, 128'h00112233_44556677_8899AABB_CCDDEEFF, 128'h195D3B7F_0F1E2D3C_A5967E5A_C3C3F00F, 1'b1);
    xfer(32'h1420, 128'hAA55A5A5, {32'hCCDDEEFF, 96'h0}, 1'b0);
    ss_val = 8'h81;
    wr(5'h18, 32'h81);
    xfer(32'h3201, 128'h1, {1'b1, 127'h0}, 1'b0);
    xfer(32'h2A07, 128'h6B, {7'h2C, 121'h0}, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule